// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Data Cache

This block keeps a small table of cache misses that have been sent to the next level of memory but have not yet come back. The cache keeps serving hits while the table holds work, and it can start further misses while earlier ones are still pending. Each live entry holds three things: the block address that missed, the cache frame picked to receive the fill, and the identifier of the instruction that asked for it. When a fill comes back, the entry returns the frame and the requester so the cache knows where to write the block and whom to wake.

Every new miss is compared with all live entries in the same cycle. A miss to a block that is already pending merges with the existing entry and sends no new request. A miss whose chosen frame is already the target of a pending fill is turned away. Any other miss takes the lowest-numbered free entry. When every entry is live, a full flag holds back new primary misses. A fill response names the entry by index, and that entry is released at the clock edge that ends the response cycle. In that same cycle its slot can be handed to a new miss.

Top module: `mshr_file`

## Requirements
- R1: After reset all entries are empty: `full` is 0, `refill_hit` is 0 for any index, and with `miss_valid` low none of `miss_accept`, `miss_merge` or `miss_conflict` is 1.
- R2: A miss whose block address and frame match no live entry, presented while a free entry exists, raises `miss_accept` in the same cycle, and `alloc_idx` gives the lowest-numbered free entry.
- R3: An accepted miss stores its block address, frame and requester tag. A later `refill_valid` with `refill_idx` naming that entry gives `refill_hit`=1 together with the stored frame on `refill_frame` and the stored tag on `refill_tag`, in the same cycle.
- R4: A miss whose block address equals that of a live entry raises `miss_merge`, with `merge_idx` set to that entry's index. It allocates nothing, even when its frame differs.
- R5: A miss whose address matches no live entry but whose frame equals a live entry's frame raises `miss_conflict` and allocates nothing.
- R6: `full` is 1 exactly when all NUM_ENTRIES (default 4) entries are live. While the table is full and no refill is presented, a miss that neither merges nor conflicts raises no outcome flag.
- R7: A refill to a live entry frees it at the edge that ends the refill cycle: `full` drops the next cycle if it was set, and that entry's frame no longer conflicts. A refill to an empty entry gives `refill_hit`=0.
- R8: An entry being refilled in the current cycle is left out of the address and frame comparisons. Its slot counts as free, so a miss in the same cycle may allocate it, and the new contents survive the release.
- R9: While `miss_valid` is low, no outcome flag rises and the table is unchanged, whatever the values on the miss inputs.
- R10: At most one of `miss_accept`, `miss_merge`, `miss_conflict` is 1. An address match takes priority over a frame match and over a full table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A new miss is presented this cycle |
| miss_addr | input | ADDR_W | Block address of the new miss |
| miss_frame | input | FRAME_W | Cache frame chosen for the fill |
| miss_tag | input | TAG_W | Identifier of the requesting instruction |
| miss_accept | output | 1 | New entry allocated; a request should be issued |
| alloc_idx | output | IDX_W | Entry taken by the accepted miss |
| miss_merge | output | 1 | Block already pending; secondary miss |
| merge_idx | output | IDX_W | Entry that already tracks the block |
| miss_conflict | output | 1 | Chosen frame is the target of a pending fill |
| refill_valid | input | 1 | A fill response is accepted this cycle |
| refill_idx | input | IDX_W | Entry the fill response belongs to |
| refill_hit | output | 1 | The named entry was live |
| refill_frame | output | FRAME_W | Destination frame of the fill |
| refill_tag | output | TAG_W | Requester to notify |
| full | output | 1 | All entries are live |

## Verification
The two functions that can fall in the same cycle are the release of an entry by a refill and the lookup and allocation of a new miss. The bench fills the table, then sends a refill to one entry together with a miss to that same entry's block address. The correct result is a fresh allocation into the slot being released, not a merge into an entry that is about to vanish. The allocation is judged by `alloc_idx` in that cycle, by `full` staying high afterwards, and by a later refill of the slot that returns the new frame and tag.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  typedef enum logic [2:0] {
    OUT_NONE,
    OUT_ALLOC,
    OUT_MERGE,
    OUT_CONFLICT,
    OUT_STALL
  } outcome_e;

  // Resolution order: address match, then frame clash, then space.
  function automatic outcome_e decide(input logic req, input logic addr_any,
                                      input logic frame_any, input logic free_any);
    if (!req)           return OUT_NONE;
    else if (addr_any)  return OUT_MERGE;
    else if (frame_any) return OUT_CONFLICT;
    else if (free_any)  return OUT_ALLOC;
    else                return OUT_STALL;
  endfunction

endpackage

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mshr_slot.sv
module mshr_slot #(
  parameter int ADDR_W  = 26,
  parameter int FRAME_W = 9,
  parameter int TAG_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic               clr_en,
  input  logic [ADDR_W-1:0]  cmp_addr,
  input  logic [FRAME_W-1:0] cmp_frame,
  output logic               valid_q,
  output logic [FRAME_W-1:0] frame_q,
  output logic [TAG_W-1:0]   tag_q,
  output logic               addr_eq,
  output logic               frame_eq
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      frame_q <= '0;
      tag_q   <= '0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      addr_q  <= wr_addr;
      frame_q <= wr_frame;
      tag_q   <= wr_tag;
    end else if (clr_en) begin
      valid_q <= 1'b0;
    end
  end

  assign addr_eq  = valid_q && (addr_q == cmp_addr);
  assign frame_eq = valid_q && (frame_q == cmp_frame);

  AST_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q && frame_q == $past(wr_frame) && tag_q == $past(wr_tag)); // R3
  AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !wr_en |=> !valid_q); // R7
  AST_SLOT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !valid_q || clr_en); // R8
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 26,
  parameter int FRAME_W     = 9,
  parameter int TAG_W       = 6,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [ADDR_W-1:0]  miss_addr,
  input  logic [FRAME_W-1:0] miss_frame,
  input  logic [TAG_W-1:0]   miss_tag,
  output logic               miss_accept,
  output logic [IDX_W-1:0]   alloc_idx,
  output logic               miss_merge,
  output logic [IDX_W-1:0]   merge_idx,
  output logic               miss_conflict,
  input  logic               refill_valid,
  input  logic [IDX_W-1:0]   refill_idx,
  output logic               refill_hit,
  output logic [FRAME_W-1:0] refill_frame,
  output logic [TAG_W-1:0]   refill_tag,
  output logic               full
);
  logic [NUM_ENTRIES-1:0] slot_valid, slot_addr_eq, slot_frame_eq;
  logic [NUM_ENTRIES-1:0] retire_vec, live_vec, addr_hit, frame_hit, free_vec, wr_vec;
  logic [FRAME_W-1:0]     slot_frame [NUM_ENTRIES];
  logic [TAG_W-1:0]       slot_tag   [NUM_ENTRIES];
  logic                   free_found, addr_found, frame_any;
  outcome_e               outcome;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      // An entry released this cycle is already treated as gone.
      assign retire_vec[g] = refill_valid && (refill_idx == IDX_W'(g)) && slot_valid[g];
      assign live_vec[g]   = slot_valid[g] && !retire_vec[g];
      assign addr_hit[g]   = live_vec[g] && slot_addr_eq[g];
      assign frame_hit[g]  = live_vec[g] && slot_frame_eq[g];
      assign free_vec[g]   = !live_vec[g];
      assign wr_vec[g]     = miss_accept && (alloc_idx == IDX_W'(g));

      mshr_slot #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .TAG_W(TAG_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_vec[g]),
        .wr_addr  (miss_addr),
        .wr_frame (miss_frame),
        .wr_tag   (miss_tag),
        .clr_en   (retire_vec[g]),
        .cmp_addr (miss_addr),
        .cmp_frame(miss_frame),
        .valid_q  (slot_valid[g]),
        .frame_q  (slot_frame[g]),
        .tag_q    (slot_tag[g]),
        .addr_eq  (slot_addr_eq[g]),
        .frame_eq (slot_frame_eq[g])
      );
    end
  endgenerate

  mshr_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_free_pick (
    .req(free_vec), .found(free_found), .idx(alloc_idx)
  );

  mshr_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_addr_pick (
    .req(addr_hit), .found(addr_found), .idx(merge_idx)
  );

  assign frame_any     = |frame_hit;
  assign outcome       = decide(miss_valid, addr_found, frame_any, free_found);
  assign miss_accept   = (outcome == OUT_ALLOC);
  assign miss_merge    = (outcome == OUT_MERGE);
  assign miss_conflict = (outcome == OUT_CONFLICT);

  assign refill_hit    = refill_valid && slot_valid[refill_idx];
  assign refill_frame  = slot_frame[refill_idx];
  assign refill_tag    = slot_tag[refill_idx];
  assign full          = &slot_valid;

  AST_NO_DUP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_hit)); // R4
  AST_NO_FRAME_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(frame_hit)); // R5
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    full && !refill_valid |-> !miss_accept); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({miss_accept, miss_merge, miss_conflict}) <= 1); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |-> !miss_accept && !miss_merge && !miss_conflict); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid && !refill_valid |=> $stable(slot_valid)); // R9
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    full && refill_hit && !miss_accept |=> !full); // R7
endmodule

// File: tb/tb_mshr_file.sv
`timescale 1ns/100ps
module tb_mshr_file;
  localparam int N = 4, AW = 26, FW = 9, TW = 6, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, refill_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic [FW-1:0] miss_frame = '0;
  logic [TW-1:0] miss_tag = '0;
  logic [IW-1:0] refill_idx = '0;
  logic miss_accept, miss_merge, miss_conflict, refill_hit, full;
  logic [IW-1:0] alloc_idx, merge_idx;
  logic [FW-1:0] refill_frame;
  logic [TW-1:0] refill_tag;

  always #2.5 clk = ~clk;

  mshr_file dut (.*);

  typedef struct { logic hit; logic [FW-1:0] frame; logic [TW-1:0] tag; string req; } fill_t;
  fill_t sb_q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares refill outputs with the scoreboard queue.
  always @(negedge clk) begin
    #2;
    if (rst_n && refill_valid && !done) begin
      if (sb_q.size() == 0) chk("R3 scoreboard empty", 1, 0);
      else begin
        fill_t e;
        e = sb_q.pop_front();
        chk({e.req, " refill_hit"}, refill_hit, e.hit);
        if (e.hit) begin
          chk({e.req, " refill_frame"}, refill_frame, e.frame);
          chk({e.req, " refill_tag"}, refill_tag, e.tag);
        end
      end
    end
  end

  // Driver: one cycle of stimulus; checks miss outcome, queues fill expectation.
  task automatic step(input string req, input logic mv, input logic [AW-1:0] a,
                      input logic [FW-1:0] f, input logic [TW-1:0] t,
                      input logic rv, input logic [IW-1:0] ri,
                      input logic [2:0] exp_out, input logic [IW-1:0] exp_idx,
                      input fill_t fe);
    @(negedge clk);
    miss_valid = mv; miss_addr = a; miss_frame = f; miss_tag = t;
    refill_valid = rv; refill_idx = ri;
    if (rv) sb_q.push_back(fe);
    #2;
    chk({req, " accept"}, miss_accept, exp_out == 3'd1);
    chk({req, " merge"}, miss_merge, exp_out == 3'd2);
    chk({req, " conflict"}, miss_conflict, exp_out == 3'd3);
    if (exp_out == 3'd1) chk({req, " alloc_idx"}, alloc_idx, exp_idx);
    if (exp_out == 3'd2) chk({req, " merge_idx"}, merge_idx, exp_idx);
    @(posedge clk);
  endtask

  task automatic chk_full(input string req, input logic exp);
    @(negedge clk);
    miss_valid = 0; refill_valid = 0;
    #2;
    chk({req, " full"}, full, exp);
  endtask

  function automatic fill_t fx(input logic h, input logic [FW-1:0] f,
                               input logic [TW-1:0] t, input string r);
    fill_t e; e.hit = h; e.frame = f; e.tag = t; e.req = r; return e;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // outcome codes: 0 none, 1 accept, 2 merge, 3 conflict
  initial begin
    fill_t nf;
    nf = fx(0, 0, 0, "none");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2;
    chk("R1 full", full, 0);
    chk("R1 accept", miss_accept, 0);
    chk("R1 merge", miss_merge, 0);
    chk("R1 conflict", miss_conflict, 0);
    step("R1 refill empty", 0, 0, 0, 0, 1, 2, 3'd0, 0, fx(0, 0, 0, "R1"));

    step("R2 first", 1, 26'h100, 9'd5, 6'd1, 0, 0, 3'd1, 0, nf);
    step("R2 second", 1, 26'h200, 9'd6, 6'd2, 0, 0, 3'd1, 1, nf);
    step("R4 secondary", 1, 26'h100, 9'd9, 6'd3, 0, 0, 3'd2, 0, nf);
    step("R5 frame clash", 1, 26'h300, 9'd6, 6'd3, 0, 0, 3'd3, 0, nf);
    step("R9 idle", 0, 26'h300, 9'd7, 6'd3, 0, 0, 3'd0, 0, nf);
    step("R2 third", 1, 26'h400, 9'd7, 6'd3, 0, 0, 3'd1, 2, nf);
    step("R2 fourth", 1, 26'h500, 9'd8, 6'd4, 0, 0, 3'd1, 3, nf);
    chk_full("R6 after four", 1);
    step("R6 stall", 1, 26'h600, 9'd10, 6'd7, 0, 0, 3'd0, 0, nf);
    step("R10 merge when full", 1, 26'h500, 9'd11, 6'd7, 0, 0, 3'd2, 3, nf);
    // Release entry 1 and miss to its block in the same cycle.
    step("R8 same cycle", 1, 26'h200, 9'd12, 6'd5, 1, 1, 3'd1, 1, fx(1, 9'd6, 6'd2, "R3"));
    chk_full("R8 slot reused", 1);
    step("R7 release", 0, 0, 0, 0, 1, 0, 3'd0, 0, fx(1, 9'd5, 6'd1, "R3 entry0"));
    chk_full("R7 full drops", 0);
    step("R7 empty refill", 0, 0, 0, 0, 1, 0, 3'd0, 0, fx(0, 0, 0, "R7"));
    step("R7 frame free", 1, 26'h700, 9'd5, 6'd6, 0, 0, 3'd1, 0, nf);
    step("R8 new contents", 0, 0, 0, 0, 1, 1, 3'd0, 0, fx(1, 9'd12, 6'd5, "R8"));
    step("R3 entry2", 0, 0, 0, 0, 1, 2, 3'd0, 0, fx(1, 9'd7, 6'd3, "R3 entry2"));
    step("R3 entry3", 0, 0, 0, 0, 1, 3, 3'd0, 0, fx(1, 9'd8, 6'd4, "R3 entry3"));
    step("R3 entry0", 0, 0, 0, 0, 1, 0, 3'd0, 0, fx(1, 9'd5, 6'd6, "R3 entry0b"));
    step("R7 clash gone", 1, 26'h800, 9'd6, 6'd1, 0, 0, 3'd1, 0, nf);
    @(negedge clk); miss_valid = 0; refill_valid = 0;
    repeat (2) @(posedge clk);
    chk("R3 scoreboard drained", sb_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule